// File: doc/BRIEF.md
# Sync Pattern Hunter and Preamble Sender

This block handles bit-level synchronization for a character-oriented synchronous serial channel. On the receive side it holds a hunt state. While hunting, every incoming serial bit is shifted into a window register. The newest bits are then compared against the low part of a programmable 16-bit sync register. A 2-bit length code picks the match width: 4, 8 or 16 bits. The code can also select external mode, where a pulse on a dedicated input replaces the pattern compare. When the pattern is found, the block leaves the hunt state. It gives a one-cycle sync indication and a bit-count clear, so the next received bit is bit 0 of the first character. From then on it passes received bits through as framed data until software requests a new hunt.

On the transmit side, a frame start loads a snapshot of the sync register. The block then sends all 16 bits, least significant bit first, one bit per line-ready handshake. It signals completion with a one-cycle pulse and then switches the line to the caller's frame data. The full register is sent whatever the receive match width is. A 4- or 8-bit pattern therefore has to be repeated across the register to form a repeating preamble. In external mode no preamble is sent and the data phase starts at once.

Top module: `sync_framer`

## Requirements
- R1: After reset, rx_hunting is 1. rx_sync_found, rx_bitcnt_clr, rx_data_valid, tx_sync_done, tx_sending_sync and tx_data_take are 0, and tx_line idles at 1.
- R2: While hunting with cfg_len = 01, 10 or 11 (4, 8 or 16 bits), a pattern hit occurs on the valid bit that completes the sequence cfg_pattern[0], cfg_pattern[1], ..., cfg_pattern[W-1] as the last W received bits, in that arrival order. Bits that do not complete such a sequence cause no hit.
- R3: A pattern hit needs at least W valid bits received since the hunt state was last entered. Bits from before a hunt request never count.
- R4: One cycle after the bit or pulse that causes a hit, rx_hunting is 0 and rx_sync_found and rx_bitcnt_clr are both 1 for exactly that one cycle.
- R5: While not hunting, every valid received bit appears on rx_data_bit with rx_data_valid = 1 in the same cycle. While hunting, rx_data_valid stays 0.
- R6: With cfg_len = 00, a pulse on ext_sync while hunting causes a hit and received bits never do. With any other code, ext_sync has no effect.
- R7: hunt_req returns the receiver to the hunt state on the next cycle, empties the bit window, and overrides a hit in the same cycle.
- R8: Once out of the hunt state, received bits that form the pattern produce no further rx_sync_found pulse.
- R9: After tx_start in idle with cfg_len != 00, tx_sending_sync is 1 and tx_line shows pattern bit k for the k-th accepted bit (k = 0..15, lowest bit first). Each cycle with tx_bit_ready = 1 accepts one bit.
- R10: tx_sync_done pulses for one cycle, the cycle after the 16th sync bit is accepted. From that cycle on, tx_line follows tx_data_bit and tx_data_take equals tx_bit_ready. tx_data_take is never 1 while sync bits are being sent.
- R11: With cfg_len = 00, tx_start sends no sync bits. tx_sync_done pulses the next cycle and the data phase begins.
- R12: tx_frame_end in the data phase returns the sender to idle (tx_line = 1, tx_data_take = 0). tx_start while not idle has no effect.
- R13: The preamble uses the cfg_pattern value sampled at tx_start. Later changes to cfg_pattern do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 2 | Sync length code: 00 external, 01 4-bit, 10 8-bit, 11 16-bit |
| cfg_pattern | input | PAT_W | Sync register |
| rx_bit_valid | input | 1 | A received serial bit is present this cycle |
| rx_bit | input | 1 | Received serial bit |
| ext_sync | input | 1 | External sync pulse (used in code 00) |
| hunt_req | input | 1 | Re-enter the hunt state |
| rx_hunting | output | 1 | Receiver is searching for sync |
| rx_sync_found | output | 1 | One-cycle sync indication |
| rx_bitcnt_clr | output | 1 | One-cycle clear for the character bit counter |
| rx_data_valid | output | 1 | Framed data bit present |
| rx_data_bit | output | 1 | Framed data bit |
| tx_start | input | 1 | Begin a frame |
| tx_bit_ready | input | 1 | Line accepts a bit this cycle |
| tx_data_bit | input | 1 | Frame data bit to send |
| tx_frame_end | input | 1 | Frame finished, return to idle |
| tx_line | output | 1 | Serial transmit bit |
| tx_sending_sync | output | 1 | Preamble in progress |
| tx_sync_done | output | 1 | One-cycle pulse, preamble complete |
| tx_data_take | output | 1 | Frame data bit consumed this cycle |

## Verification
The hardest receive situation to reach is a 16-bit match that a pseudo-random stream almost never produces by chance. A close second is a hit that would be fake, formed partly from bits left in the window before a hunt request. The bench runs a reference of the last received bits for every pattern in the 4-bit space and for a spread of 8- and 16-bit patterns. If no hit comes within the random prefix, it appends the exact pattern bits. It also sends an all-zero pattern right after a hunt request, so that a leftover window would fire one bit early. On transmit, ready gaps and a tx_start plus a pattern change in the middle of the preamble test that bit ordering survives stalls.

// File: rtl/sync_pkg.sv
`timescale 1ns/1ps
package sync_pkg;
  typedef enum logic [1:0] {
    LEN_EXT = 2'b00,
    LEN_Q   = 2'b01,
    LEN_H   = 2'b10,
    LEN_F   = 2'b11
  } sync_len_e;

  typedef enum logic [1:0] {
    TXS_IDLE = 2'b00,
    TXS_PRE  = 2'b01,
    TXS_DATA = 2'b10
  } tx_state_e;

  // Compare width for a length code: quarter, half or full register.
  function automatic int unsigned match_width(input logic [1:0] code, input int unsigned full_w);
    case (code)
      LEN_Q:   return full_w / 4;
      LEN_H:   return full_w / 2;
      LEN_F:   return full_w;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sync_rx_hunter.sv
`timescale 1ns/1ps
module sync_rx_hunter
  import sync_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       len,
  input  logic [PAT_W-1:0] pattern,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             ext_sync,
  input  logic             hunt_req,
  output logic             hunting,
  output logic             sync_found,
  output logic             cnt_clr,
  output logic             data_valid,
  output logic             data_bit,
  output logic             lock_ev
);
  localparam int CNT_W = $clog2(PAT_W + 1);

  // Newest bit enters at the top; the oldest bit of a W-bit window sits at PAT_W-W.
  function automatic logic window_hit(input logic [PAT_W-1:0] win,
                                      input logic [PAT_W-1:0] pat,
                                      input int unsigned w);
    logic [PAT_W-1:0] mask;
    mask = {PAT_W{1'b1}} >> (PAT_W - w);
    return ((win >> (PAT_W - w)) & mask) == (pat & mask);
  endfunction

  logic [PAT_W-1:0] win_q, win_nxt;
  logic [CNT_W-1:0] fill_q, fill_nxt;
  int unsigned      width;
  logic             pat_hit, ext_hit;

  always_comb begin
    width    = match_width(len, PAT_W);
    win_nxt  = {bit_in, win_q[PAT_W-1:1]};
    fill_nxt = (32'(fill_q) >= PAT_W) ? fill_q : fill_q + 1'b1;
    pat_hit  = hunting && bit_valid && (len != LEN_EXT) &&
               (32'(fill_nxt) >= width) && window_hit(win_nxt, pattern, width);
    ext_hit  = hunting && (len == LEN_EXT) && ext_sync;
    lock_ev  = (pat_hit || ext_hit) && !hunt_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= '0;
      fill_q     <= '0;
      hunting    <= 1'b1;
      sync_found <= 1'b0;
      cnt_clr    <= 1'b0;
    end else begin
      sync_found <= lock_ev;
      cnt_clr    <= lock_ev;
      if (hunt_req) begin
        hunting <= 1'b1;
        win_q   <= '0;
        fill_q  <= '0;
      end else begin
        if (lock_ev) hunting <= 1'b0;
        if (bit_valid) begin
          win_q  <= win_nxt;
          fill_q <= fill_nxt;
        end
      end
    end
  end

  assign data_valid = !hunting && bit_valid;
  assign data_bit   = bit_in;
endmodule

// File: rtl/sync_tx_preamble.sv
`timescale 1ns/1ps
module sync_tx_preamble
  import sync_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       len,
  input  logic [PAT_W-1:0] pattern,
  input  logic             start,
  input  logic             bit_ready,
  input  logic             data_bit,
  input  logic             frame_end,
  output logic             line,
  output logic             sending_sync,
  output logic             sync_done,
  output logic             data_take,
  output logic             last_ev
);
  localparam int IDX_W = $clog2(PAT_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_W - 1);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PAT_W-1:0] snap_q;

  assign last_ev = (state_q == TXS_PRE) && bit_ready && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TXS_IDLE;
      idx_q     <= '0;
      snap_q    <= '0;
      sync_done <= 1'b0;
    end else begin
      sync_done <= 1'b0;
      case (state_q)
        TXS_IDLE: if (start) begin
          snap_q <= pattern;
          idx_q  <= '0;
          if (len == LEN_EXT) begin
            state_q   <= TXS_DATA;
            sync_done <= 1'b1;
          end else begin
            state_q <= TXS_PRE;
          end
        end
        TXS_PRE: if (bit_ready) begin
          if (last_ev) begin
            state_q   <= TXS_DATA;
            sync_done <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        TXS_DATA: if (frame_end) state_q <= TXS_IDLE;
        default: state_q <= TXS_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      TXS_PRE:  line = snap_q[idx_q];
      TXS_DATA: line = data_bit;
      default:  line = 1'b1;
    endcase
  end

  assign sending_sync = (state_q == TXS_PRE);
  assign data_take    = (state_q == TXS_DATA) && bit_ready;
endmodule

// File: rtl/sync_framer.sv
`timescale 1ns/1ps
module sync_framer
  import sync_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_len,
  input  logic [PAT_W-1:0] cfg_pattern,
  input  logic             rx_bit_valid,
  input  logic             rx_bit,
  input  logic             ext_sync,
  input  logic             hunt_req,
  output logic             rx_hunting,
  output logic             rx_sync_found,
  output logic             rx_bitcnt_clr,
  output logic             rx_data_valid,
  output logic             rx_data_bit,
  input  logic             tx_start,
  input  logic             tx_bit_ready,
  input  logic             tx_data_bit,
  input  logic             tx_frame_end,
  output logic             tx_line,
  output logic             tx_sending_sync,
  output logic             tx_sync_done,
  output logic             tx_data_take
);
  // Internal events exposed for the checker.
  logic rx_lock_ev;
  logic tx_last_ev;

  sync_rx_hunter #(.PAT_W(PAT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .len        (cfg_len),
    .pattern    (cfg_pattern),
    .bit_valid  (rx_bit_valid),
    .bit_in     (rx_bit),
    .ext_sync   (ext_sync),
    .hunt_req   (hunt_req),
    .hunting    (rx_hunting),
    .sync_found (rx_sync_found),
    .cnt_clr    (rx_bitcnt_clr),
    .data_valid (rx_data_valid),
    .data_bit   (rx_data_bit),
    .lock_ev    (rx_lock_ev)
  );

  sync_tx_preamble #(.PAT_W(PAT_W)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .len          (cfg_len),
    .pattern      (cfg_pattern),
    .start        (tx_start),
    .bit_ready    (tx_bit_ready),
    .data_bit     (tx_data_bit),
    .frame_end    (tx_frame_end),
    .line         (tx_line),
    .sending_sync (tx_sending_sync),
    .sync_done    (tx_sync_done),
    .data_take    (tx_data_take),
    .last_ev      (tx_last_ev)
  );
endmodule

// File: rtl/sync_framer_chk.sv
`timescale 1ns/1ps
module sync_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic hunt_req,
  input logic rx_hunting,
  input logic rx_sync_found,
  input logic rx_bitcnt_clr,
  input logic rx_data_valid,
  input logic rx_lock_ev,
  input logic tx_bit_ready,
  input logic tx_line,
  input logic tx_sending_sync,
  input logic tx_sync_done,
  input logic tx_data_take,
  input logic tx_last_ev
);
  // R4
  lock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lock_ev |=> (rx_sync_found && rx_bitcnt_clr && !rx_hunting));
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync_found |=> !rx_sync_found);
  // R4
  leave_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_hunting && $past(rx_hunting)) |-> rx_sync_found);
  // R5
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data_valid |-> !rx_hunting);
  // R7
  hunt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_req |=> (rx_hunting && !rx_sync_found));
  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_ev |=> (tx_sync_done && !tx_sending_sync));
  // R10
  no_take_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_take |-> !tx_sending_sync);
  // R9
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sending_sync && !tx_bit_ready && !tx_last_ev) |=> $stable(tx_line));
endmodule

bind sync_framer sync_framer_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .hunt_req        (hunt_req),
  .rx_hunting      (rx_hunting),
  .rx_sync_found   (rx_sync_found),
  .rx_bitcnt_clr   (rx_bitcnt_clr),
  .rx_data_valid   (rx_data_valid),
  .rx_lock_ev      (rx_lock_ev),
  .tx_bit_ready    (tx_bit_ready),
  .tx_line         (tx_line),
  .tx_sending_sync (tx_sending_sync),
  .tx_sync_done    (tx_sync_done),
  .tx_data_take    (tx_data_take),
  .tx_last_ev      (tx_last_ev)
);

// File: tb/sync_framer_tb.sv
`timescale 1ns/1ps
module sync_framer_tb;
  localparam int  PAT_W = 16;
  localparam time CLK_T = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_len;
  logic [PAT_W-1:0] cfg_pattern;
  logic rx_bit_valid, rx_bit, ext_sync, hunt_req;
  logic rx_hunting, rx_sync_found, rx_bitcnt_clr, rx_data_valid, rx_data_bit;
  logic tx_start, tx_bit_ready, tx_data_bit, tx_frame_end;
  logic tx_line, tx_sending_sync, tx_sync_done, tx_data_take;

  always #(CLK_T/2) clk = ~clk;

  sync_framer #(.PAT_W(PAT_W)) u_dut (.*);

  int total = 0;
  int bad   = 0;
  bit hist [0:511];
  int hcnt;
  logic [15:0] lfsr;

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int width_of(input logic [1:0] code);
    return (code == 2'b01) ? 4 : (code == 2'b10) ? 8 : (code == 2'b11) ? 16 : 0;
  endfunction

  // Reference: value built from the last w received bits, first-arrived as bit 0.
  function automatic bit model_hit(input int w, input logic [PAT_W-1:0] pat);
    int v = 0;
    if (w == 0 || hcnt < w) return 1'b0;
    for (int j = 0; j < w; j++) v += int'(hist[hcnt-w+j]) * (1 << j);
    return v == (int'(pat) % (1 << w));
  endfunction

  function automatic bit next_rand();
    bit b = lfsr[0];
    lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    return b;
  endfunction

  task automatic do_hunt();
    @(negedge clk); hunt_req = 1'b1;
    @(negedge clk); hunt_req = 1'b0;
    check_eq("R7 hunt state after request", int'(rx_hunting), 1);
    hcnt = 0;
  endtask

  // One valid bit, then one idle cycle; outputs checked at the idle negedge.
  task automatic send_bit(input bit b, input bit locked);
    @(negedge clk); rx_bit = b; rx_bit_valid = 1'b1;
    #1;
    check_eq(locked ? "R5 data valid when locked" : "R5 no data while hunting",
             int'(rx_data_valid), locked ? 1 : 0);
    if (locked) check_eq("R5 data bit", int'(rx_data_bit), int'(b));
    @(negedge clk); rx_bit_valid = 1'b0;
  endtask

  task automatic hunt_run(input logic [1:0] code, input logic [PAT_W-1:0] pat,
                          input logic [15:0] seed, input int prefix);
    int w = width_of(code);
    bit got = 1'b0;
    cfg_len = code; cfg_pattern = pat; lfsr = seed;
    do_hunt();
    for (int k = 0; k < prefix + w && !got; k++) begin
      bit b = (k < prefix) ? next_rand() : pat[k - prefix];
      hist[hcnt] = b; hcnt++;
      send_bit(b, 1'b0);
      got = model_hit(w, pat);
      check_eq("R2 sync found", int'(rx_sync_found), int'(got));
      check_eq("R4 counter clear", int'(rx_bitcnt_clr), int'(got));
      check_eq("R4 hunt flag", int'(rx_hunting), int'(!got));
    end
    check_eq("R2 lock reached", int'(got), 1);
    for (int j = 0; j < w; j++) begin
      send_bit(pat[j], 1'b1);
      check_eq("R4 R8 no repeat pulse", int'(rx_sync_found), 0);
    end
  endtask

  task automatic tx_run(input logic [1:0] code, input logic [PAT_W-1:0] pat,
                        input logic [15:0] gaps);
    @(negedge clk); cfg_len = code; cfg_pattern = pat; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    #1;
    if (code == 2'b00) begin
      check_eq("R11 done without preamble", int'(tx_sync_done), 1);
      check_eq("R11 no sync sending", int'(tx_sending_sync), 0);
    end else begin
      check_eq("R9 sync sending", int'(tx_sending_sync), 1);
      cfg_pattern = ~pat;
      for (int k = 0; k < 16; k++) begin
        if (gaps[k]) begin
          check_eq("R9 bit held in gap", int'(tx_line), int'(pat[k]));
          check_eq("R10 no take in sync", int'(tx_data_take), 0);
          @(negedge clk);
        end
        tx_bit_ready = 1'b1;
        if (k == 5) tx_start = 1'b1;
        #1;
        check_eq("R9 R13 sync bit", int'(tx_line), int'(pat[k]));
        check_eq("R10 no take in sync", int'(tx_data_take), 0);
        @(negedge clk); tx_bit_ready = 1'b0; tx_start = 1'b0;
        #1;
        check_eq("R10 done pulse", int'(tx_sync_done), (k == 15) ? 1 : 0);
      end
    end
    @(negedge clk);
    check_eq("R10 done is one cycle", int'(tx_sync_done), 0);
    for (int d = 0; d < 4; d++) begin
      tx_data_bit = d[0] ^ pat[d]; tx_bit_ready = 1'b1;
      #1;
      check_eq("R10 data on line", int'(tx_line), int'(tx_data_bit));
      check_eq("R10 data take", int'(tx_data_take), 1);
      @(negedge clk); tx_bit_ready = 1'b0;
    end
    tx_frame_end = 1'b1;
    @(negedge clk); tx_frame_end = 1'b0; tx_bit_ready = 1'b1;
    #1;
    check_eq("R12 idle line", int'(tx_line), 1);
    check_eq("R12 idle no take", int'(tx_data_take), 0);
    @(negedge clk); tx_bit_ready = 1'b0;
  endtask

  initial begin
    #(CLK_T * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_len = 2'b01; cfg_pattern = 16'hA5A5;
    rx_bit_valid = 1'b0; rx_bit = 1'b0; ext_sync = 1'b0; hunt_req = 1'b0;
    tx_start = 1'b0; tx_bit_ready = 1'b1; tx_data_bit = 1'b0; tx_frame_end = 1'b0;
    hcnt = 0; lfsr = 16'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 hunting", int'(rx_hunting), 1);
    check_eq("R1 no sync", int'(rx_sync_found), 0);
    check_eq("R1 no clear", int'(rx_bitcnt_clr), 0);
    check_eq("R1 no data", int'(rx_data_valid), 0);
    check_eq("R1 idle line", int'(tx_line), 1);
    check_eq("R1 no take", int'(tx_data_take), 0);
    check_eq("R1 no done", int'(tx_sync_done), 0);
    check_eq("R1 not sending", int'(tx_sending_sync), 0);
    tx_bit_ready = 1'b0;

    // 4-bit: every pattern value, random prefix.
    for (int p = 0; p < 16; p++)
      hunt_run(2'b01, PAT_W'(p) | 16'h3C50, 16'(p * 977 + 11), 20);
    // 8-bit spread.
    for (int p = 0; p < 8; p++)
      hunt_run(2'b10, PAT_W'(p * 37 + 3), 16'(p * 531 + 7), 40);
    // 16-bit: near-certain to need the appended pattern.
    for (int p = 0; p < 4; p++)
      hunt_run(2'b11, PAT_W'(p * 16'h3F1D + 16'h0F0F), 16'(p * 77 + 5), 30);

    // R3: all-zero 16-bit pattern right after a hunt that follows a zero stream.
    cfg_len = 2'b11; cfg_pattern = '0;
    do_hunt();
    for (int k = 0; k < 16; k++) begin
      send_bit(1'b0, 1'b0);
      check_eq("R3 window fill", int'(rx_sync_found), (k == 15) ? 1 : 0);
    end
    for (int k = 0; k < 16; k++) send_bit(1'b0, 1'b1);
    do_hunt();
    for (int k = 0; k < 15; k++) begin
      send_bit(1'b0, 1'b0);
      check_eq("R3 R7 old bits ignored", int'(rx_hunting), 1);
    end
    send_bit(1'b0, 1'b0);
    check_eq("R3 lock at full fill", int'(rx_sync_found), 1);

    // R7: hunt request overrides a completing bit.
    cfg_len = 2'b01; cfg_pattern = 16'h0005;
    do_hunt();
    for (int k = 0; k < 3; k++) send_bit(cfg_pattern[k], 1'b0);
    @(negedge clk); rx_bit = 1'b0; rx_bit_valid = 1'b1; hunt_req = 1'b1;
    @(negedge clk); rx_bit_valid = 1'b0; hunt_req = 1'b0;
    check_eq("R7 override hit", int'(rx_sync_found), 0);
    check_eq("R7 still hunting", int'(rx_hunting), 1);

    // R6: external mode.
    cfg_len = 2'b00; cfg_pattern = 16'h0000;
    do_hunt();
    for (int k = 0; k < 20; k++) begin
      send_bit(1'b0, 1'b0);
      check_eq("R6 bits ignored in external mode", int'(rx_hunting), 1);
    end
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    check_eq("R6 external lock", int'(rx_sync_found), 1);
    check_eq("R6 external leaves hunt", int'(rx_hunting), 0);
    send_bit(1'b1, 1'b1);
    cfg_len = 2'b10;
    do_hunt();
    @(negedge clk); ext_sync = 1'b1;
    @(negedge clk); ext_sync = 1'b0;
    check_eq("R6 pulse ignored in pattern mode", int'(rx_sync_found), 0);
    check_eq("R6 still hunting", int'(rx_hunting), 1);

    // Transmit sweeps.
    tx_run(2'b11, 16'hB38E, 16'h0000);
    tx_run(2'b01, 16'h5555, 16'h8421);
    tx_run(2'b10, 16'hC3A7, 16'hFFFF);
    tx_run(2'b11, 16'h0001, 16'h1248);
    tx_run(2'b00, 16'h9F31, 16'h0000);

    summary();
  end
endmodule